// File: doc/BRIEF.md
# Multi-channel UTOPIA Level 2 transmit receiver (PHY side)

This block sits on the PHY side of a 16-bit UTOPIA Level 2 bus in the ATM-to-PHY direction and serves four channels. Each channel has its own 5-bit bus address, which comes from a per-channel configuration input. The ATM master polls a channel by putting its address on the bus. One clock later the block answers on a cell-available line, and it drives that line only while one of its own addresses is present.

The master selects a channel by holding that channel's address while the enable line is high and then pulling enable low. From then on the block takes one 16-bit word per clock while enable stays low. The first word carries a start-of-cell flag. A cell is 27 words: 5 header bytes, one filler byte and 48 payload bytes. Each word is checked for odd parity. A finished cell is stored in a small per-channel cell buffer, and a local consumer reads the buffers out one word at a time through a simple pop port.

Top module: `utopia2_tx_phy`

## Requirements
- R1: `cav` is a registered answer to the address presented one clock earlier. It is high only if that address belongs to a channel whose buffer has room for a whole 27-word cell. A channel counts as having room when its stored cells plus any cell it is receiving number fewer than NCELL (2).
- R2: `cav_oe` is high in a cycle exactly when the address on `bus_addr` in the previous cycle matched one of the channel addresses. Otherwise it is low.
- R3: A channel becomes selected when `bus_en_n` goes from high to low and the address in the last cycle with `bus_en_n` high was that channel's address. Words sent while no channel of this block is selected are not stored.
- R4: While selected, one word is taken on each clock with `bus_en_n` low. Cycles with `bus_en_n` high take no word. After such a pause the master reselects the channel and the cell continues where it stopped.
- R5: A cell becomes readable only after all 27 of its words have arrived. A partial cell never shows on the pop port.
- R6: Parity is odd: the XOR of the 16 data bits and `bus_par` must be 1. A word that breaks this sets that channel's bit in `par_err`, which stays set until reset. The cell is still stored.
- R7: If `bus_soc` arrives while a channel is partway through a cell, the partial cell is discarded and a new cell starts with that word. That channel's bit in `runt_err` is set and stays set until reset.
- R8: A word without `bus_soc` that arrives when the selected channel is not inside a cell is ignored.
- R9: `pop_rdy` is high when the channel chosen by `pop_ch` holds at least one whole cell. `pop_data` shows that cell's next word, and `pop_first` is high on its first word. `pop_en` with `pop_rdy` advances to the next word at the clock edge. Cells come out in arrival order.
- R10: After reset, `cav`, `cav_oe`, `pop_rdy`, `par_err` and `runt_err` are all zero.
- R11: Channel c takes its address from `chan_addr[5c+4:5c]`, and each channel's buffer is separate from the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_addr | input | 20 | Per-channel 5-bit bus addresses, channel c at bits 5c+4:5c |
| bus_addr | input | 5 | Address driven by the ATM master |
| bus_en_n | input | 1 | Transfer enable, active low |
| bus_data | input | 16 | Cell word |
| bus_par | input | 1 | Odd parity bit for bus_data |
| bus_soc | input | 1 | Start of cell, high with word 0 |
| cav | output | 1 | Cell-available answer to a poll |
| cav_oe | output | 1 | Output enable for cav |
| pop_ch | input | 2 | Channel to read |
| pop_en | input | 1 | Advance the read by one word |
| pop_rdy | output | 1 | Selected channel holds a whole cell |
| pop_first | output | 1 | pop_data is word 0 of a cell |
| pop_data | output | 16 | Head word of the selected channel |
| par_err | output | 4 | Sticky parity error per channel |
| runt_err | output | 4 | Sticky short-cell error per channel |

## Verification
The properties assume that `bus_addr` and `chan_addr` always carry known values. They also assume that the master polls a channel and sees room before it starts a new cell there. The stimulus keeps to this. It puts the unused address 31 on the bus whenever it is idle, keeps the four channel addresses distinct, and polls before every cell that it expects to be stored. Any cell sent without room is aimed at an address that belongs to no channel.

// File: rtl/utopia2_tx_phy.sv
module utopia2_tx_phy #(
  parameter int NCH        = 4,
  parameter int AW         = 5,
  parameter int DW         = 16,
  parameter int CELL_WORDS = 27,
  parameter int NCELL      = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH*AW-1:0]        chan_addr,
  input  logic [AW-1:0]            bus_addr,
  input  logic                     bus_en_n,
  input  logic [DW-1:0]            bus_data,
  input  logic                     bus_par,
  input  logic                     bus_soc,
  output logic                     cav,
  output logic                     cav_oe,
  input  logic [$clog2(NCH)-1:0]   pop_ch,
  input  logic                     pop_en,
  output logic                     pop_rdy,
  output logic                     pop_first,
  output logic [DW-1:0]            pop_data,
  output logic [NCH-1:0]           par_err,
  output logic [NCH-1:0]           runt_err
);
  localparam int CW    = $clog2(NCH);
  localparam int DEPTH = NCELL * CELL_WORDS;
  localparam int IW    = $clog2(CELL_WORDS);
  localparam int SW    = $clog2(NCELL);
  localparam int NW    = $clog2(NCELL + 1);
  localparam int MW    = $clog2(NCH * DEPTH);

  logic [DW-1:0] mem [NCH*DEPTH];
  logic [IW-1:0] widx [NCH];
  logic [IW-1:0] ridx [NCH];
  logic [SW-1:0] wcell [NCH];
  logic [SW-1:0] rcell [NCH];
  logic [NW-1:0] ccnt [NCH];

  logic          en_q, cand_v, sel_v;
  logic [CW-1:0] cand_ch, sel_ch;
  logic          hit;
  logic [CW-1:0] hit_ch;
  logic [NCH-1:0] room, commit, rel;

  always_comb begin
    hit    = 1'b0;
    hit_ch = '0;
    for (int c = NCH - 1; c >= 0; c--)
      if (chan_addr[c*AW +: AW] == bus_addr) begin
        hit    = 1'b1;
        hit_ch = CW'(c);
      end
  end

  wire          fall   = en_q & ~bus_en_n;
  wire          cur_v  = fall ? cand_v : sel_v;
  wire [CW-1:0] cur_ch = fall ? cand_ch : sel_ch;
  wire          take   = ~bus_en_n & cur_v;
  wire          mid    = widx[cur_ch] != '0;
  wire          accept = take & (bus_soc ? (mid | room[cur_ch]) : mid);
  wire [IW-1:0] eff    = bus_soc ? '0 : widx[cur_ch];
  wire          last   = eff == IW'(CELL_WORDS - 1);
  wire          par_bad = ~^{bus_data, bus_par};
  wire          popped = pop_en & pop_rdy;

  wire [MW-1:0] waddr = MW'(int'(cur_ch) * DEPTH + int'(wcell[cur_ch]) * CELL_WORDS + int'(eff));
  wire [MW-1:0] raddr = MW'(int'(pop_ch) * DEPTH + int'(rcell[pop_ch]) * CELL_WORDS + int'(ridx[pop_ch]));

  assign pop_rdy   = ccnt[pop_ch] != '0;
  assign pop_first = ridx[pop_ch] == '0;
  assign pop_data  = mem[raddr];

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      room[c]   = (int'(ccnt[c]) + int'(widx[c] != '0)) < NCELL;
      commit[c] = accept && last && cur_ch == CW'(c);
      rel[c]    = popped && pop_ch == CW'(c) && ridx[c] == IW'(CELL_WORDS - 1);
    end
  end

  always_ff @(posedge clk)
    if (accept) mem[waddr] <= bus_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b1;
      cand_v   <= 1'b0;
      cand_ch  <= '0;
      sel_v    <= 1'b0;
      sel_ch   <= '0;
      cav      <= 1'b0;
      cav_oe   <= 1'b0;
      par_err  <= '0;
      runt_err <= '0;
      for (int c = 0; c < NCH; c++) begin
        widx[c]  <= '0;
        ridx[c]  <= '0;
        wcell[c] <= '0;
        rcell[c] <= '0;
        ccnt[c]  <= '0;
      end
    end else begin
      en_q <= bus_en_n;
      if (bus_en_n) begin
        cand_v  <= hit;
        cand_ch <= hit_ch;
      end
      if (fall) begin
        sel_v  <= cand_v;
        sel_ch <= cand_ch;
      end
      cav_oe <= hit;
      cav    <= hit & room[hit_ch];
      for (int c = 0; c < NCH; c++) begin
        if (accept && cur_ch == CW'(c)) begin
          widx[c] <= last ? '0 : IW'(int'(eff) + 1);
          if (last) wcell[c] <= (wcell[c] == SW'(NCELL - 1)) ? '0 : wcell[c] + 1'b1;
          if (par_bad) par_err[c] <= 1'b1;
          if (bus_soc && mid) runt_err[c] <= 1'b1;
        end
        if (popped && pop_ch == CW'(c)) begin
          ridx[c] <= rel[c] ? '0 : ridx[c] + 1'b1;
          if (rel[c]) rcell[c] <= (rcell[c] == SW'(NCELL - 1)) ? '0 : rcell[c] + 1'b1;
        end
        ccnt[c] <= NW'(int'(ccnt[c]) + int'(commit[c]) - int'(rel[c]));
      end
    end
  end
endmodule

module utopia2_tx_phy_chk #(
  parameter int NCH = 4,
  parameter int AW  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH*AW-1:0] chan_addr,
  input logic [AW-1:0]     bus_addr,
  input logic              cav,
  input logic              cav_oe,
  input logic [NCH-1:0]    par_err,
  input logic [NCH-1:0]    runt_err
);
  logic any_hit, armed;

  always_comb begin
    any_hit = 1'b0;
    for (int c = 0; c < NCH; c++)
      if (chan_addr[c*AW +: AW] == bus_addr) any_hit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else armed <= 1'b1;

  a_r1_cav_only_when_driven: assert property (@(posedge clk) disable iff (!rst_n)
    cav |-> cav_oe);

  a_r2_oe_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    armed && cav_oe |-> $past(any_hit));

  a_r2_match_gives_oe: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(any_hit) |-> cav_oe);

  a_r6_parity_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((par_err & $past(par_err)) == $past(par_err)));

  a_r7_runt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((runt_err & $past(runt_err)) == $past(runt_err)));
endmodule

bind utopia2_tx_phy utopia2_tx_phy_chk #(.NCH(NCH), .AW(AW)) u_chk (.*);

// File: tb/utopia2_tx_phy_test.sv
`timescale 1ns/1ps
module utopia2_tx_phy_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] chan_addr = {5'd0, 5'd30, 5'd17, 5'd5};
  logic [4:0]  bus_addr;
  logic        bus_en_n, bus_par, bus_soc;
  logic [15:0] bus_data;
  logic        cav, cav_oe;
  logic [1:0]  pop_ch;
  logic        pop_en;
  logic        pop_rdy, pop_first;
  logic [15:0] pop_data;
  logic [3:0]  par_err, runt_err;

  always #2.5 clk = ~clk;

  utopia2_tx_phy uut (.*);

  int n_cmp = 0, n_bad = 0, popped = 0;
  bit drain = 0;
  logic [18:0] exp_q[$];

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] wd(int ch, int tag, int i);
    return 16'(ch * 4096 + tag * 32 + i);
  endfunction

  // monitor: pops words and compares against the scoreboard (R9)
  initial begin
    pop_ch = 0;
    pop_en = 0;
    forever begin
      @(negedge clk);
      pop_en = 0;
      if (drain && rst_n) begin
        if (pop_rdy) begin
          int k = -1;
          foreach (exp_q[j]) if (k < 0 && exp_q[j][18:17] == pop_ch) k = j;
          if (k < 0) chk(0, "R9", "unexpected word", pop_data, 0);
          else begin
            chk({pop_first, pop_data} == exp_q[k][16:0], "R9", "popped word",
                {pop_first, pop_data}, exp_q[k][16:0]);
            exp_q.delete(k);
          end
          popped++;
          pop_en = 1;
        end else pop_ch = pop_ch + 1;
      end
    end
  end

  task automatic send(int a, int ch, int tag, int first, int n, bit bad, bit pz, bit push);
    @(negedge clk);
    bus_addr = 5'(a); bus_en_n = 1; bus_soc = 0;
    for (int i = first; i < first + n; i++) begin
      @(negedge clk);
      if (pz && i == first + 4) begin
        bus_en_n = 1; bus_soc = 0; bus_data = 16'hdead;  // R4 pause
        @(negedge clk);
      end
      bus_en_n = 0;
      bus_soc  = (i == 0);
      bus_data = wd(ch, tag, i);
      bus_par  = ~^bus_data ^ (bad && i == 3);
      if (push) exp_q.push_back({2'(ch), 1'(i == 0), bus_data});
    end
    @(negedge clk);
    bus_en_n = 1; bus_soc = 0; bus_addr = 5'd31;
  endtask

  task automatic poll(int a, bit eo, bit ec, string req);
    @(negedge clk);
    bus_addr = 5'(a); bus_en_n = 1;
    @(negedge clk);
    chk(cav_oe == eo, req, "cav_oe", cav_oe, eo);
    if (eo) chk(cav == ec, req, "cav", cav, ec);
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    int p;
    rst_n = 0; bus_addr = 5'd31; bus_en_n = 1; bus_soc = 0; bus_data = 0; bus_par = 1;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk(cav_oe == 0, "R10", "cav_oe", cav_oe, 0);
    chk(cav == 0, "R10", "cav", cav, 0);
    chk(pop_rdy == 0, "R10", "pop_rdy", pop_rdy, 0);
    chk(par_err == 0 && runt_err == 0, "R10", "errors", {par_err, runt_err}, 0);

    poll(9, 0, 0, "R2");
    poll(17, 1, 1, "R1");
    poll(5, 1, 1, "R11");
    poll(0, 1, 1, "R11");

    send(17, 1, 1, 0, 27, 0, 1, 1);   // R4 with pause
    poll(17, 1, 1, "R1 one slot left");
    send(17, 1, 2, 0, 27, 0, 0, 1);
    poll(17, 1, 0, "R1 full");
    poll(5, 1, 1, "R11 other channel");
    drain = 1;
    wait_drain();
    poll(17, 1, 1, "R1 room again");
    chk(popped == 54, "R5", "words popped", popped, 54);

    send(30, 2, 3, 0, 27, 1, 0, 1);
    wait_drain();
    chk(par_err == 4'b0100, "R6", "par_err", par_err, 4'b0100);
    chk(runt_err == 0, "R6", "runt_err", runt_err, 0);

    send(5, 0, 4, 0, 10, 0, 0, 0);
    send(5, 0, 5, 0, 27, 0, 0, 1);
    wait_drain();
    chk(runt_err == 4'b0001, "R7", "runt_err", runt_err, 4'b0001);

    send(0, 3, 6, 5, 3, 0, 0, 0);     // R8 stray words
    send(0, 3, 7, 0, 27, 0, 0, 1);
    wait_drain();
    chk(runt_err == 4'b0001, "R8", "runt_err", runt_err, 4'b0001);

    p = popped;
    send(9, 0, 8, 0, 27, 0, 0, 0);    // R3 unmatched address
    repeat (60) @(negedge clk);
    chk(popped == p, "R3", "words popped", popped, p);

    p = popped;
    send(0, 3, 9, 0, 26, 0, 1, 1);
    repeat (60) @(negedge clk);
    chk(popped == p, "R5", "partial hidden", popped, p);
    send(0, 3, 9, 26, 1, 0, 0, 1);
    wait_drain();
    chk(popped == p + 27, "R5", "completed cell", popped, p + 27);
    chk(exp_q.size() == 0, "R9", "pending words", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule